// File: doc/BRIEF.md
# Cascaded Serial ADC Chain Reader

This block sits on the host side of a string of identical serial converters that are wired in cascade and share a single data return line. Every converter shares the same serial clock, chip select and synchronization line, and the far end of the string has its serial input grounded. When the converter nearest the host pulls its active-low data-ready line low, the reader starts a frame. It drives the serial clock for exactly one 24-bit word per device and samples the return line. It then hands the words back one per cycle. Each word carries the position of its device in the string.

The return line updates on each falling serial clock edge. The reader samples it on the following rising edge, half a clock period later. Bits arrive most significant first. The nearest device's word comes first and the farthest device's word comes last. The reader holds a complete frame internally and releases it only when every bit has arrived. If data-ready goes high too early, the frame is dropped and a one-cycle error pulse is raised. Chip select can be tied low permanently or driven for the duration of the frame, chosen by a parameter. A request input produces a fixed-width active-low synchronization pulse, which starts the conversions of all devices together. If the configured serial clock cannot fit a whole frame inside the declared data-ready low time, elaboration stops with an error.

Top module: `adc_chain_reader`

## Requirements
- R1: While reset is asserted and right after it is released, the outputs are: `sclk` = 1, `sync_n` = 1, `word_valid` = 0, `frame_err` = 0. `cs_n` is 1 in driven mode (CS_DRIVEN = 1) and 0 in tied mode (CS_DRIVEN = 0).
- R2: After each falling edge of `drdy_n`, exactly N_DEV×24 falling edges appear on `sclk` before `drdy_n` rises again, provided `drdy_n` stays low long enough. At all other times `sclk` rests at 1.
- R3: The reader samples `sdo` on each rising edge of `sclk`. Each word is 24 consecutive samples, with the first sample going to bit 23 (most significant).
- R4: After a complete frame, the reader raises `word_valid` for N_DEV consecutive cycles, one word per cycle. The n-th word in the frame is presented with `word_idx` = n, where 0 is the device nearest the host, whose word is first on the line.
- R5: In driven mode, `cs_n` is 0 at every falling edge of `sclk` and returns to 1 once the frame ends. In tied mode, `cs_n` is 0 at all times.
- R6: If `drdy_n` rises before all N_DEV×24 bits are sampled, `frame_err` is 1 for exactly one cycle and the frame produces no `word_valid` pulse. `sclk` goes back to 1, and the next frame is read correctly.
- R7: A one-cycle `sync_req` drives `sync_n` low for exactly SYNC_CYC cycles. Any request that arrives while the pulse is running is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sync_req | input | 1 | One-cycle request for a synchronization pulse |
| sync_n | output | 1 | Active-low synchronization pulse to every device |
| drdy_n | input | 1 | Active-low data-ready from the nearest device |
| sdo | input | 1 | Serial data returned by the chain |
| sclk | output | 1 | Serial clock; rests at 1 |
| cs_n | output | 1 | Active-low chip select (driven or tied low) |
| word_data | output | 24 | Received conversion word |
| word_idx | output | $clog2(N_DEV) (min 1) | Chain position of `word_data`, 0 = nearest |
| word_valid | output | 1 | High for one cycle per presented word |
| frame_err | output | 1 | One-cycle pulse when a frame is cut short |

## Verification
The bench runs two readers side by side, one with chip select driven and one with it tied low. Each reader is fed by a behavioural cascade that shifts on the falling edge of the serial clock. Frames of all zeros and all ones show whether the reader counts falling edges exactly and keeps the frame boundaries, independent of the data. A single set bit walked through every one of the 72 positions of a three-device frame exposes any bit-order, word-split or device-index mistake, because each position maps to exactly one expected word and bit. Frames built from arithmetic mixes separate the word order from the bit order. Frames cut short at two different depths, followed by a good frame, show whether partial data is suppressed and the reader recovers cleanly.

// File: rtl/adc_chain_pkg.sv
// Shared definitions for the cascaded ADC chain reader.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package adc_chain_pkg;

    // Frame engine states: waiting for data-ready, clocking bits, waiting for data-ready to rise.
    typedef enum logic [1:0] {
        FR_IDLE  = 2'd0,
        FR_SHIFT = 2'd1,
        FR_DRAIN = 2'd2
    } frame_state_e;

endpackage

// File: rtl/chain_sync_pulse.sv
// Generates the shared active-low synchronization pulse.
// A one-cycle request starts a pulse SYNC_CYC cycles long; requests during a pulse are dropped.
// Assumes: sync_req is synchronous to clk.
module chain_sync_pulse #(
    parameter int SYNC_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_req,
    output logic sync_n
);

    localparam int CNT_W = $clog2(SYNC_CYC + 1);

    logic [CNT_W-1:0] remain_q;

    // Load the pulse length on an accepted request, then count it down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
        end else if (remain_q == '0) begin
            if (sync_req) begin
                remain_q <= CNT_W'(SYNC_CYC);
            end
        end else begin
            remain_q <= remain_q - 1'b1;
        end
    end

    assign sync_n = (remain_q == '0);

endmodule

// File: rtl/chain_serial_engine.sv
// Frame engine: watches data-ready, drives the serial clock (and chip select when driven),
// samples the return line on each rising clock edge, and writes each finished 24-bit word
// into the word bank with its chain position.
// Assumes: drdy_n is asynchronous and is synchronized here. sdo changes only after falling
// sclk edges, which this block produces itself. SCLK_DIV is the half period in clk cycles.
module chain_serial_engine
    import adc_chain_pkg::*;
#(
    parameter int N_DEV     = 4,
    parameter int WORD_W    = 24,
    parameter int SCLK_DIV  = 2,
    parameter bit CS_DRIVEN = 1'b1,
    parameter int IDX_W     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              drdy_n,
    input  logic              sdo,
    output logic              sclk,
    output logic              cs_n,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [WORD_W-1:0] wr_data,
    output logic              frame_done,
    output logic              frame_err
);

    localparam int BIT_W = $clog2(WORD_W);
    localparam int DIV_W = (SCLK_DIV > 1) ? $clog2(SCLK_DIV) : 1;

    frame_state_e      state_q;
    logic [2:0]        drdy_pipe_q;
    logic [DIV_W-1:0]  div_q;
    logic [BIT_W-1:0]  bit_q;
    logic [IDX_W-1:0]  word_q;
    logic [WORD_W-1:0] shift_q;
    logic              sclk_q;

    logic              drdy_lvl;
    logic              drdy_fall;
    logic              half_tick;
    logic              last_bit;
    logic              last_word;
    logic [WORD_W-1:0] shift_next;

    // Bring data-ready into the clock domain and keep one older copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drdy_pipe_q <= 3'b111;
        end else begin
            drdy_pipe_q <= {drdy_pipe_q[1:0], drdy_n};
        end
    end

    // Decode data-ready level and edge, divider expiry and frame position.
    always_comb begin
        drdy_lvl   = drdy_pipe_q[1];
        drdy_fall  = drdy_pipe_q[2] & ~drdy_pipe_q[1];
        half_tick  = (div_q == DIV_W'(SCLK_DIV - 1));
        last_bit   = (bit_q == BIT_W'(WORD_W - 1));
        last_word  = (word_q == IDX_W'(N_DEV - 1));
        shift_next = {shift_q[WORD_W-2:0], sdo};
    end

    // Frame state machine, serial clock divider and bit capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= FR_IDLE;
            div_q      <= '0;
            bit_q      <= '0;
            word_q     <= '0;
            shift_q    <= '0;
            sclk_q     <= 1'b1;
            wr_en      <= 1'b0;
            wr_idx     <= '0;
            wr_data    <= '0;
            frame_done <= 1'b0;
            frame_err  <= 1'b0;
        end else begin
            wr_en      <= 1'b0;
            frame_done <= 1'b0;
            frame_err  <= 1'b0;
            case (state_q)
                FR_IDLE: begin
                    if (drdy_fall) begin
                        state_q <= FR_SHIFT;
                        div_q   <= '0;
                        bit_q   <= '0;
                        word_q  <= '0;
                        sclk_q  <= 1'b1;
                    end
                end
                FR_SHIFT: begin
                    if (drdy_lvl) begin
                        state_q   <= FR_IDLE;
                        sclk_q    <= 1'b1;
                        frame_err <= 1'b1;
                    end else if (half_tick) begin
                        div_q  <= '0;
                        sclk_q <= ~sclk_q;
                        if (!sclk_q) begin
                            shift_q <= shift_next;
                            if (last_bit) begin
                                bit_q   <= '0;
                                wr_en   <= 1'b1;
                                wr_idx  <= word_q;
                                wr_data <= shift_next;
                                word_q  <= word_q + 1'b1;
                                if (last_word) begin
                                    state_q    <= FR_DRAIN;
                                    frame_done <= 1'b1;
                                end
                            end else begin
                                bit_q <= bit_q + 1'b1;
                            end
                        end
                    end else begin
                        div_q <= div_q + 1'b1;
                    end
                end
                FR_DRAIN: begin
                    if (drdy_lvl) begin
                        state_q <= FR_IDLE;
                    end
                end
                default: begin
                    state_q <= FR_IDLE;
                end
            endcase
        end
    end

    assign sclk = sclk_q;

    // Chip select variant picked by parameter: frame-wide select, or held low permanently.
    generate
        if (CS_DRIVEN) begin : g_cs_driven
            assign cs_n = (state_q != FR_SHIFT);
        end else begin : g_cs_tied
            assign cs_n = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/chain_word_bank.sv
// One register per chain position, holding the words of the frame in progress.
// Assumes: only one write per cycle. Reads are combinational by index.
module chain_word_bank #(
    parameter int N_DEV  = 4,
    parameter int WORD_W = 24,
    parameter int IDX_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_data
);

    logic [WORD_W-1:0] slot_q [N_DEV];

    generate
        for (genvar i = 0; i < N_DEV; i++) begin : g_slot
            // Capture the word addressed to this position.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    slot_q[i] <= '0;
                end else if (wr_en && (wr_idx == IDX_W'(i))) begin
                    slot_q[i] <= wr_data;
                end
            end
        end
    endgenerate

    // Select the slot addressed by the sequencer.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < N_DEV; i++) begin
            if (rd_idx == IDX_W'(i)) begin
                rd_data = slot_q[i];
            end
        end
    end

endmodule

// File: rtl/chain_word_sequencer.sv
// Releases a finished frame word by word, nearest device first, one word per cycle.
// Assumes: frame_done arrives at least N_DEV cycles apart, which any legal frame guarantees.
module chain_word_sequencer #(
    parameter int N_DEV  = 4,
    parameter int WORD_W = 24,
    parameter int IDX_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_done,
    input  logic [WORD_W-1:0] rd_data,
    output logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] word_data,
    output logic [IDX_W-1:0]  word_idx,
    output logic              word_valid
);

    logic             busy_q;
    logic [IDX_W-1:0] idx_q;

    // Walk the index from 0 to N_DEV-1 after each completed frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
        end else if (frame_done) begin
            busy_q <= 1'b1;
            idx_q  <= '0;
        end else if (busy_q) begin
            if (idx_q == IDX_W'(N_DEV - 1)) begin
                busy_q <= 1'b0;
            end else begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    assign rd_idx     = idx_q;
    assign word_valid = busy_q;
    assign word_idx   = idx_q;
    assign word_data  = busy_q ? rd_data : '0;

endmodule

// File: rtl/adc_chain_reader.sv
// Top level of the cascaded ADC chain reader. Connects the sync pulse generator, the frame
// engine, the word bank and the output sequencer.
// Assumes: data-ready stays low for at least DRDY_LOW_CYC clk cycles per conversion. The
// configuration check below refuses settings whose frame would not fit in that window.
module adc_chain_reader #(
    parameter int N_DEV        = 4,
    parameter int WORD_W       = 24,
    parameter int SCLK_DIV     = 2,
    parameter bit CS_DRIVEN    = 1'b1,
    parameter int SYNC_CYC     = 4,
    parameter int DRDY_LOW_CYC = 1000,
    parameter int IDX_W        = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_req,
    output logic              sync_n,
    input  logic              drdy_n,
    input  logic              sdo,
    output logic              sclk,
    output logic              cs_n,
    output logic [WORD_W-1:0] word_data,
    output logic [IDX_W-1:0]  word_idx,
    output logic              word_valid,
    output logic              frame_err
);

    localparam int FRAME_BITS   = N_DEV * WORD_W;
    localparam int FRAME_CYC    = FRAME_BITS * 2 * SCLK_DIV;
    localparam int SETUP_MARGIN = 8;

    // Reject configurations whose frame cannot finish inside the data-ready low window.
    generate
        if (N_DEV < 1 || N_DEV > 8 || SCLK_DIV < 1 || WORD_W < 2 ||
            FRAME_CYC + SETUP_MARGIN > DRDY_LOW_CYC) begin : g_cfg_bad
            $error("adc_chain_reader: frame of %0d cycles exceeds data-ready window %0d",
                   FRAME_CYC + SETUP_MARGIN, DRDY_LOW_CYC);
        end
    endgenerate

    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    logic [WORD_W-1:0] wr_data;
    logic              frame_done;
    logic [IDX_W-1:0]  rd_idx;
    logic [WORD_W-1:0] rd_data;

    chain_sync_pulse #(
        .SYNC_CYC (SYNC_CYC)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_req (sync_req),
        .sync_n   (sync_n)
    );

    chain_serial_engine #(
        .N_DEV     (N_DEV),
        .WORD_W    (WORD_W),
        .SCLK_DIV  (SCLK_DIV),
        .CS_DRIVEN (CS_DRIVEN),
        .IDX_W     (IDX_W)
    ) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .drdy_n     (drdy_n),
        .sdo        (sdo),
        .sclk       (sclk),
        .cs_n       (cs_n),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_data    (wr_data),
        .frame_done (frame_done),
        .frame_err  (frame_err)
    );

    chain_word_bank #(
        .N_DEV  (N_DEV),
        .WORD_W (WORD_W),
        .IDX_W  (IDX_W)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_idx  (rd_idx),
        .rd_data (rd_data)
    );

    chain_word_sequencer #(
        .N_DEV  (N_DEV),
        .WORD_W (WORD_W),
        .IDX_W  (IDX_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_done (frame_done),
        .rd_data    (rd_data),
        .rd_idx     (rd_idx),
        .word_data  (word_data),
        .word_idx   (word_idx),
        .word_valid (word_valid)
    );

endmodule

// File: rtl/adc_chain_reader_chk.sv
// Protocol checker for adc_chain_reader, attached by bind. It watches only the top-level ports.
// Assumes: reset is asserted at start-up.
module adc_chain_reader_chk #(
    parameter int N_DEV    = 4,
    parameter int WORD_W   = 24,
    parameter int SYNC_CYC = 4,
    parameter int IDX_W    = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             drdy_n,
    input logic             sclk,
    input logic             cs_n,
    input logic             sync_n,
    input logic             word_valid,
    input logic [IDX_W-1:0] word_idx,
    input logic             frame_err
);

    localparam int FRAME_BITS = N_DEV * WORD_W;
    localparam int FALL_W     = $clog2(FRAME_BITS + 2);
    localparam int SLOW_W     = $clog2(SYNC_CYC + 2);
    localparam logic [IDX_W-1:0] IDX_ONE  = IDX_W'(1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(N_DEV - 1);

    logic              sclk_prev_q;
    logic              drdy_prev_q;
    logic [FALL_W-1:0] fall_cnt_q;
    logic [SLOW_W-1:0] sync_low_q;

    // Count serial clock falls since the most recent data-ready fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_prev_q <= 1'b1;
            drdy_prev_q <= 1'b1;
            fall_cnt_q  <= '0;
        end else begin
            sclk_prev_q <= sclk;
            drdy_prev_q <= drdy_n;
            if (drdy_prev_q && !drdy_n) begin
                fall_cnt_q <= '0;
            end else if (sclk_prev_q && !sclk && fall_cnt_q != '1) begin
                fall_cnt_q <= fall_cnt_q + 1'b1;
            end
        end
    end

    // Measure how long the synchronization pulse has been low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_low_q <= '0;
        end else if (sync_n) begin
            sync_low_q <= '0;
        end else if (sync_low_q != '1) begin
            sync_low_q <= sync_low_q + 1'b1;
        end
    end

    AST_FALLS_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        fall_cnt_q <= FALL_W'(FRAME_BITS)); // R2

    AST_SCLK_LOW_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        !sclk |-> !cs_n); // R5

    AST_FIRST_IDX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && !$past(word_valid)) |-> (word_idx == '0)); // R4

    AST_IDX_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && $past(word_valid)) |-> (word_idx == IDX_W'($past(word_idx) + IDX_ONE))); // R4

    AST_RUN_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && word_idx == IDX_LAST) |=> !word_valid); // R4

    AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |=> !frame_err); // R6

    AST_ERR_NO_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |-> !word_valid); // R6

    AST_SYNC_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        sync_low_q <= SLOW_W'(SYNC_CYC)); // R7

endmodule

bind adc_chain_reader adc_chain_reader_chk #(
    .N_DEV    (N_DEV),
    .WORD_W   (WORD_W),
    .SYNC_CYC (SYNC_CYC),
    .IDX_W    (IDX_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .drdy_n     (drdy_n),
    .sclk       (sclk),
    .cs_n       (cs_n),
    .sync_n     (sync_n),
    .word_valid (word_valid),
    .word_idx   (word_idx),
    .frame_err  (frame_err)
);

// File: tb/adc_chain_reader_bench.sv
`timescale 1ns/1ps

// Behavioural cascade of converters: it loads a fresh frame on the first falling serial clock
// edge of each new frame and then shifts one bit per falling edge, feeding in zeros.
module adc_chain_model #(
    parameter int BITS = 72
) (
    input  logic            sclk,
    input  logic            cs_n,
    input  int              frame_id,
    input  logic [BITS-1:0] load_bits,
    output logic            sdo
);
    logic [BITS-1:0] sr;
    int              loaded_id;

    initial begin
        sdo       = 1'b0;
        sr        = '0;
        loaded_id = 0;
    end

    always @(negedge sclk) begin
        if (!cs_n) begin
            if (loaded_id != frame_id) begin
                sr        = load_bits;
                loaded_id = frame_id;
            end
            sdo = sr[BITS-1];
            sr  = {sr[BITS-2:0], 1'b0};
        end
    end
endmodule

module adc_chain_reader_bench;

    localparam int K     = 3;
    localparam int W     = 24;
    localparam int NB    = K * W;
    localparam int DIV   = 2;
    localparam int SYNCC = 4;
    localparam int LOWC  = 320;
    localparam int IW    = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sync_req = 1'b0;
    logic drdy_n = 1'b1;
    logic [NB-1:0] frame_bits = '0;
    int   frame_id = 0;

    logic          sdo_w   [2];
    logic          sync_w  [2];
    logic          sclk_w  [2];
    logic          cs_w    [2];
    logic [W-1:0]  wd_w    [2];
    logic [IW-1:0] wi_w    [2];
    logic          wv_w    [2];
    logic          err_w   [2];

    int n_cmp  = 0;
    int n_fail = 0;
    int cyc    = 0;

    // Monitor state, cleared at the start of each frame.
    logic [W-1:0]  cap_data [2][8];
    int            cap_idx  [2][8];
    int            cap_cyc  [2][8];
    int            cap_n    [2];
    int            err_cyc  [2];
    int            falls    [2];
    logic          sclk_prev[2];
    int            cs_bad   [2];
    int            sync_low;

    always #2.5 clk = ~clk;

    adc_chain_reader #(
        .N_DEV(K), .WORD_W(W), .SCLK_DIV(DIV), .CS_DRIVEN(1'b1),
        .SYNC_CYC(SYNCC), .DRDY_LOW_CYC(LOWC)
    ) u_adc_chain_reader (
        .clk(clk), .rst_n(rst_n), .sync_req(sync_req), .sync_n(sync_w[0]),
        .drdy_n(drdy_n), .sdo(sdo_w[0]), .sclk(sclk_w[0]), .cs_n(cs_w[0]),
        .word_data(wd_w[0]), .word_idx(wi_w[0]), .word_valid(wv_w[0]), .frame_err(err_w[0])
    );

    adc_chain_reader #(
        .N_DEV(K), .WORD_W(W), .SCLK_DIV(DIV), .CS_DRIVEN(1'b0),
        .SYNC_CYC(SYNCC), .DRDY_LOW_CYC(LOWC)
    ) u_adc_chain_reader_tied (
        .clk(clk), .rst_n(rst_n), .sync_req(sync_req), .sync_n(sync_w[1]),
        .drdy_n(drdy_n), .sdo(sdo_w[1]), .sclk(sclk_w[1]), .cs_n(cs_w[1]),
        .word_data(wd_w[1]), .word_idx(wi_w[1]), .word_valid(wv_w[1]), .frame_err(err_w[1])
    );

    adc_chain_model #(.BITS(NB)) u_model0 (
        .sclk(sclk_w[0]), .cs_n(cs_w[0]), .frame_id(frame_id), .load_bits(frame_bits), .sdo(sdo_w[0]));
    adc_chain_model #(.BITS(NB)) u_model1 (
        .sclk(sclk_w[1]), .cs_n(cs_w[1]), .frame_id(frame_id), .load_bits(frame_bits), .sdo(sdo_w[1]));

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic clear_mon();
        for (int d = 0; d < 2; d++) begin
            cap_n[d]   = 0;
            err_cyc[d] = 0;
            falls[d]   = 0;
            cs_bad[d]  = 0;
        end
        sync_low = 0;
    endtask

    // Sample every output mid-cycle, away from the active clock edge.
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            for (int d = 0; d < 2; d++) begin
                if (wv_w[d] && cap_n[d] < 8) begin
                    cap_data[d][cap_n[d]] = wd_w[d];
                    cap_idx[d][cap_n[d]]  = int'(wi_w[d]);
                    cap_cyc[d][cap_n[d]]  = cyc;
                    cap_n[d]++;
                end
                if (err_w[d]) err_cyc[d]++;
                if (sclk_prev[d] && !sclk_w[d]) begin
                    falls[d]++;
                    if (cs_w[d]) cs_bad[d]++;
                end
                sclk_prev[d] = sclk_w[d];
            end
            if (cs_w[1]) cs_bad[1]++;
            if (!sync_w[0]) sync_low++;
        end else begin
            sclk_prev[0] = 1'b1;
            sclk_prev[1] = 1'b1;
        end
    end

    task automatic run_frame(input logic [NB-1:0] bits, input int low_cyc, input bit good);
        @(negedge clk);
        clear_mon();
        frame_bits = bits;
        frame_id++;
        drdy_n = 1'b0;
        repeat (low_cyc) @(negedge clk);
        drdy_n = 1'b1;
        repeat (30) @(negedge clk);
        for (int d = 0; d < 2; d++) begin
            if (good) begin
                chk(falls[d] == NB, "R2 falling edge count", falls[d], NB);
                chk(err_cyc[d] == 0, "R6 no error on full frame", err_cyc[d], 0);
                chk(cap_n[d] == K, "R4 word count", cap_n[d], K);
                for (int j = 0; j < K && j < cap_n[d]; j++) begin
                    chk(cap_data[d][j] == bits[NB-1-j*W -: W], "R3 word bits",
                        cap_data[d][j], bits[NB-1-j*W -: W]);
                    chk(cap_idx[d][j] == j, "R4 word index", cap_idx[d][j], j);
                    chk(cap_cyc[d][j] - cap_cyc[d][0] == j, "R4 consecutive cycles",
                        cap_cyc[d][j] - cap_cyc[d][0], j);
                end
            end else begin
                chk(cap_n[d] == 0, "R6 dropped frame emits nothing", cap_n[d], 0);
                chk(err_cyc[d] == 1, "R6 error pulse width", err_cyc[d], 1);
                chk(falls[d] < NB, "R6 frame cut short", falls[d], NB);
            end
            chk(sclk_w[d] == 1'b1, "R2 sclk rests high", sclk_w[d], 1);
            chk(cs_bad[d] == 0, "R5 chip select during frame", cs_bad[d], 0);
        end
        chk(cs_w[0] == 1'b1, "R5 driven select released", cs_w[0], 1);
    endtask

    function automatic logic [NB-1:0] mix_frame(input int s);
        logic [NB-1:0] f;
        for (int j = 0; j < K; j++) begin
            f[NB-1-j*W -: W] = W'(s * 32'h0F1E2D + j * 32'h135791 + 32'h00A501);
        end
        return f;
    endfunction

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=done", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

    initial begin
        clear_mon();
        repeat (5) @(negedge clk);
        // R1: state while reset is held.
        chk(sclk_w[0] == 1'b1, "R1 sclk in reset", sclk_w[0], 1);
        chk(cs_w[0] == 1'b1, "R1 driven cs in reset", cs_w[0], 1);
        chk(cs_w[1] == 1'b0, "R1 tied cs in reset", cs_w[1], 0);
        chk(sync_w[0] == 1'b1, "R1 sync in reset", sync_w[0], 1);
        chk(wv_w[0] == 1'b0 && wv_w[1] == 1'b0, "R1 valid in reset", wv_w[0], 0);
        chk(err_w[0] == 1'b0 && err_w[1] == 1'b0, "R1 error in reset", err_w[0], 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(sclk_w[0] == 1'b1 && sclk_w[1] == 1'b1, "R1 sclk after reset", sclk_w[0], 1);
        chk(cs_w[0] == 1'b1, "R1 driven cs after reset", cs_w[0], 1);

        // R7: single pulse, then a pulse with a second request inside it.
        clear_mon();
        sync_req = 1'b1; @(negedge clk); sync_req = 1'b0;
        repeat (10) @(negedge clk);
        chk(sync_low == SYNCC, "R7 sync pulse width", sync_low, SYNCC);
        clear_mon();
        sync_req = 1'b1; @(negedge clk); sync_req = 1'b0;
        @(negedge clk);
        sync_req = 1'b1; @(negedge clk); sync_req = 1'b0;
        repeat (10) @(negedge clk);
        chk(sync_low == SYNCC, "R7 request during pulse ignored", sync_low, SYNCC);

        // R2 R3 R4 R5: fixed, walking and arithmetic frames.
        run_frame('0, LOWC, 1'b1);
        run_frame('1, LOWC, 1'b1);
        run_frame({(NB/2){2'b10}}, LOWC, 1'b1);
        for (int p = 0; p < NB; p++) begin
            run_frame(NB'(1) << p, LOWC, 1'b1);
        end
        for (int p = 0; p < NB; p += 7) begin
            run_frame(~(NB'(1) << p), LOWC, 1'b1);
        end
        for (int s = 0; s < 8; s++) begin
            run_frame(mix_frame(s), LOWC, 1'b1);
        end

        // R6: frames cut short at two depths, each followed by a good frame.
        run_frame(mix_frame(20), 100, 1'b0);
        run_frame(mix_frame(21), LOWC, 1'b1);
        run_frame(mix_frame(22), 250, 1'b0);
        run_frame(mix_frame(23), LOWC, 1'b1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

endmodule